// File: doc/BRIEF.md
# Wide-to-byte frame width converter

This block takes frame data one wide word at a time and sends it out as a stream of single bytes. Each input word is 68 bits wide. The low 64 bits are payload. The top four bits are a sideband field. That field says how many bytes of the word are valid and whether the word closes a frame. The block is meant for a 125 MHz datapath. It sits between a source that delivers frames in wide words and a byte-serial encoder further down the line.

An upstream source hands over a word through a valid/ready handshake. The converter holds the word and sends one byte per cycle, least significant byte first. It drops the unused upper bytes of a short final word. It raises an end-of-frame pulse together with the last byte of a frame. It holds ready low while more than one byte of the current word is still to be sent. A non-final word that claims to be short is a protocol fault. Such a word sets an error flag that stays set until reset.

Top module: `frame_word_unpacker`

## Requirements
- R1: While reset is held and just after it is released, out_valid and out_eof are low, in_ready is high and err_sticky is low.
- R2: The input word is split into fields: bit 67 is the last-word flag, bits 66:64 are the valid-byte count, and bits 63:0 are the payload. A count of 0 means all 8 bytes are valid. A word is taken in on a rising edge where in_valid and in_ready are both high.
- R3: The bytes of an accepted word leave in the order data[7:0], data[15:8], and so on. They come one per cycle on consecutive cycles. The first byte is on out_byte with out_valid high in the cycle right after the accepting edge.
- R4: Only as many bytes as the count field gives are sent. Upper bytes beyond the count never appear.
- R5: out_eof is high exactly with the final byte sent from a word whose last-word flag is 1. It is never high with any other byte, and never high when out_valid is low.
- R6: in_ready is high when no byte is on the output, or when the byte on the output is the final byte of the current word. Otherwise it is low. Back-to-back words therefore leave no idle cycle between them.
- R7: A word accepted with the last-word flag at 0 and a count other than 0 sets err_sticky on the accepting edge. The block still sends exactly the counted number of bytes for that word.
- R8: Once set, err_sticky stays high until reset, whatever words follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 125 MHz domain |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Block can take a word this cycle |
| in_word | input | 68 | Sideband (bits 67:64) and payload (bits 63:0) |
| out_valid | output | 1 | out_byte holds a valid byte |
| out_byte | output | 8 | Output byte |
| out_eof | output | 1 | Marks the last byte of a frame |
| err_sticky | output | 1 | A non-final word was not full |

## Verification
The bench targets several corner cases. It sends a count of 0 and expects eight bytes; a design that read 0 literally would send nothing or hang. Short final words of length 1 and 7 check the trimming of bytes; an off-by-one shows up as an extra or missing byte, or as the end-of-frame pulse on the wrong byte. Back-to-back words with no gap test the early ready on the final byte. A block that held ready until fully idle would insert a gap, and one that opened ready too early would overwrite bytes still pending. A short non-final word must set the error flag and keep it through later good frames; a non-sticky flag, or one raised by full words, shows up at once.

// File: rtl/frame_word_unpacker.sv
module frame_word_unpacker #(
  parameter int LANES  = 8,
  parameter int BYTE_W = 8,
  localparam int CNT_W  = $clog2(LANES),
  localparam int DATA_W = LANES * BYTE_W,
  localparam int IN_W   = DATA_W + CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IN_W-1:0]   in_word,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_eof,
  output logic              err_sticky
);

  logic [DATA_W-1:0] shift_q;
  logic [CNT_W:0]    rem_q;
  logic              last_q;
  logic              err_q;

  logic              accept;
  logic [CNT_W-1:0]  cnt_f;
  logic              last_f;
  logic [CNT_W:0]    nbytes;

  assign cnt_f  = in_word[DATA_W +: CNT_W];
  assign last_f = in_word[IN_W-1];
  assign nbytes = (cnt_f == '0) ? (CNT_W+1)'(LANES) : {1'b0, cnt_f};

  assign in_ready   = (rem_q <= (CNT_W+1)'(1));
  assign accept     = in_valid && in_ready;
  assign out_valid  = (rem_q != '0);
  assign out_byte   = shift_q[BYTE_W-1:0];
  assign out_eof    = last_q && (rem_q == (CNT_W+1)'(1));
  assign err_sticky = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
      rem_q   <= '0;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (accept) begin
        shift_q <= in_word[DATA_W-1:0];
        rem_q   <= nbytes;
        last_q  <= last_f;
        if (!last_f && cnt_f != '0) err_q <= 1'b1;
      end else if (rem_q != '0) begin
        shift_q <= shift_q >> BYTE_W;
        rem_q   <= rem_q - (CNT_W+1)'(1);
      end
    end
  end

endmodule

// File: rtl/frame_word_unpacker_chk.sv
module frame_word_unpacker_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic [BYTE_W-1:0] out_byte,
  input logic              out_eof,
  input logic              err_sticky
);

  logic unused_ok;
  assign unused_ok = ^out_byte;

  AST_EOF_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_valid); // R5

  AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R6

  AST_BUSY_KEEPS_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> out_valid); // R6

  AST_ACCEPT_STARTS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R3

  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky); // R8

  AST_IDLE_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_eof && !in_valid) |=> !out_valid); // R4

endmodule

bind frame_word_unpacker frame_word_unpacker_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_byte(out_byte), .out_eof(out_eof),
  .err_sticky(err_sticky)
);

// File: tb/frame_word_unpacker_bench.sv
module frame_word_unpacker_bench;
  localparam int CLK_PERIOD = 8;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [67:0] in_word = '0;
  logic        in_ready, out_valid, out_eof, err_sticky;
  logic [7:0]  out_byte;

  int n_checks = 0;
  int n_fail   = 0;
  logic [8:0] expq[$];
  logic       exp_err = 1'b0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_word_unpacker u_frame_word_unpacker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_byte(out_byte),
    .out_eof(out_eof), .err_sticky(err_sticky)
  );

  function automatic logic [67:0] mk_word(bit last, int cnt, logic [63:0] d);
    return {last, cnt[2:0], d};
  endfunction

  function automatic int nbytes_of(logic [67:0] w);
    return (w[66:64] == 3'd0) ? 8 : int'(w[66:64]);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Sample at negedge, compare, then drive the next input.
  task automatic step(bit v, logic [67:0] w);
    logic [8:0] e;
    @(negedge clk);
    if (out_valid) begin
      if (expq.size() == 0) begin
        chk(0, "R4", "unexpected byte", out_byte, 0);
      end else begin
        e = expq.pop_front();
        chk(out_byte == e[7:0], "R3", "byte value", out_byte, e[7:0]);
        chk(out_eof == e[8], "R5", "eof", out_eof, e[8]);
      end
    end else begin
      chk(expq.size() == 0, "R3", "missing byte", 0, expq.size());
      chk(out_eof == 1'b0, "R5", "eof without byte", out_eof, 0);
    end
    chk(in_ready == (expq.size() == 0), "R6", "in_ready", in_ready, expq.size() == 0);
    chk(err_sticky == exp_err, "R7/R8", "err_sticky", err_sticky, exp_err);
    in_valid = v;
    in_word  = w;
    if (v && in_ready) begin
      int n = nbytes_of(w);
      for (int i = 0; i < n; i++)
        expq.push_back({(i == n-1) && w[67], w[i*8 +: 8]});
      if (!w[67] && w[66:64] != 3'd0) exp_err = 1'b1; // R7
    end
  endtask

  task automatic send(bit last, int cnt, logic [63:0] d);
    logic [67:0] w = mk_word(last, cnt, d);
    do step(1'b1, w); while (!(in_valid && in_ready));
  endtask

  task automatic drain();
    while (expq.size() != 0) step(1'b0, '0);
    step(1'b0, '0);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: values during reset
    chk(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
    chk(in_ready == 1, "R1", "in_ready in reset", in_ready, 1);
    chk(err_sticky == 0, "R1", "err in reset", err_sticky, 0);
    chk(out_eof == 0, "R1", "eof in reset", out_eof, 0);
    rst_n = 1'b1;
    step(1'b0, '0);

    // R2, R4: count 0 means full word
    send(1'b1, 0, 64'h8877_6655_4433_2211);
    drain();
    // R4, R5: short final words
    send(1'b1, 1, 64'hFFFF_FFFF_FFFF_FFA5);
    drain();
    send(1'b1, 7, 64'hEEDD_CCBB_AA99_8877);
    drain();
    // R6: back-to-back frame of three words, no gaps
    send(1'b0, 0, 64'h0706_0504_0302_0100);
    send(1'b0, 0, 64'h0F0E_0D0C_0B0A_0908);
    send(1'b1, 3, 64'h1717_1717_1712_1110);
    send(1'b1, 2, 64'h0000_0000_0000_BEEF);
    drain();
    chk(err_sticky == 0, "R7", "no error on good frames", err_sticky, 0);
    // R7: short non-final word sets error, still trims
    send(1'b0, 3, 64'h1111_1111_11C3_C2C1);
    send(1'b1, 0, 64'h2222_3333_4444_5555);
    drain();
    chk(err_sticky == 1, "R7", "error after short non-final", err_sticky, 1);
    // R8: stays set through good traffic
    send(1'b1, 4, 64'h0123_4567_89AB_CDEF);
    drain();
    chk(err_sticky == 1, "R8", "error still set", err_sticky, 1);

    // Reset clears the flag, then random traffic
    rst_n = 1'b0;
    expq.delete();
    exp_err = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(err_sticky == 0, "R1", "err after reset", err_sticky, 0);
    rst_n = 1'b1;

    for (int k = 0; k < 4000; k++) begin
      bit v = ($urandom_range(0, 3) != 0);
      bit last = ($urandom_range(0, 3) == 0);
      int cnt = 0;
      if (last) cnt = $urandom_range(0, 7);
      else if ($urandom_range(0, 31) == 0 && k > 2000) cnt = $urandom_range(1, 7);
      step(v, mk_word(last, cnt, {$urandom, $urandom}));
    end
    drain();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule